// File: doc/BRIEF.md
# CAN Node Status and Error Counter Unit

This unit holds the status and fault-confinement state of one CAN node. A protocol engine, which is not part of this block, reports each bus event as a single-cycle strobe. The strobes cover a successfully sent frame, a successfully received frame, a detected error with its three-bit code, and requests to raise or lower the transmit and receive error counters. From the two counters the unit derives three confinement flags: warning, error-passive and bus-off. It also records the code of the most recent bus event.

Software reaches the unit through a small four-word register port and is notified through one interrupt line. The interrupt fires when a confinement flag changes or when the event code is rewritten. Software can store the value 7 ("nothing happened") in the event-code field. Because the engine never produces 7, any later change in that field proves that a bus event occurred.

The parameter `CLEAR_ON_READ` selects how the sticky status bits are acknowledged. With 0, software acknowledges them by writing the status word. With 1, reading the status word clears them.

Top module: `can_status_unit`

## Requirements
- R1: After reset the status word reads 0x0007, the counter word reads 0x0000, the control word reads 0x0000, the interrupt-ID word reads 0x0000, and `irq` is low.
- R2: Status word layout: bit 7 bus-off, bit 6 warning, bit 5 passive, bit 4 RX done, bit 3 TX done, bits 2:0 event code. The event codes are 0 none, 1 stuff, 2 form, 3 ack, 4 bit-recessive, 5 bit-dominant, 6 CRC and 7 parked. A TX-done strobe sets bit 3 and an RX-done strobe sets bit 4; either one loads code 0. An error strobe with a code from 0 to 6 loads that code and takes priority over a done strobe in the same cycle. An error strobe with code 7 leaves the field unchanged.
- R3: With `CLEAR_ON_READ`=0, a write to the status word (address 1) loads bits 4:0 from the write data. Bits 7:5 are not writable, and a read changes nothing.
- R4: With `CLEAR_ON_READ`=1, a status read returns the current value, then clears bits 4:3 and sets the event code to 7.
- R5: The counter word (address 2) holds the transmit count in bits 7:0. A transmit increment adds `TEC_STEP` (8). A transmit decrement subtracts 1 and never goes below 0.
- R6: The warning flag is set while either counter is at or above `WARN_LIMIT` (96).
- R7: The passive flag is set while the transmit count exceeds `PASSIVE_LIMIT` (127) or the receive-passive bit is set. A receive count of exactly 127 does not set it.
- R8: An increment that would take the transmit count past 255 enters bus-off. The count is then held at 255, and bit 7 together with the warning and passive flags stays set until reset. Transmit decrements have no effect during bus-off.
- R9: The receive count sits in counter-word bits 14:8 and adds `REC_STEP` (1) per increment. An increment past 127 holds the count at 127 and sets bit 15, the receive-passive bit. The first decrement after that clears bit 15 only; later decrements subtract 1.
- R10: A flag change or an event-code update marks a status interrupt pending on the second rising edge after its cause, and only while control bit 0 is set. `irq` equals pending AND control bit 0. The interrupt-ID word (address 3) reads 0x8000 while an interrupt is pending. A status read clears the pending mark.
- R11: Register reads are registered: `bus_rdata` shows the addressed word from the clock edge that samples `bus_rd`. The control word is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_ok | input | 1 | Frame sent successfully (strobe) |
| ev_rx_ok | input | 1 | Frame received successfully (strobe) |
| ev_err | input | 1 | Bus error detected (strobe) |
| ev_err_code | input | 3 | Code that goes with `ev_err` |
| ev_tec_inc | input | 1 | Raise transmit error count |
| ev_tec_dec | input | 1 | Lower transmit error count |
| ev_rec_inc | input | 1 | Raise receive error count |
| ev_rec_dec | input | 1 | Lower receive error count |
| bus_addr | input | 2 | Word select: 0 control, 1 status, 2 counters, 3 interrupt ID |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Status-change interrupt |

## Verification
The bench drives each counter exactly to its thresholds: 95/96 for warning, 127/128 for passive, and 255 against one more increment for bus-off. A design with an off-by-one comparison would raise or drop a flag one strobe early or late. A design whose counter wraps at 255 would report a count near zero instead of bus-off. The bench also checks the receive-passive bit at saturation and how it is released by a decrement, an error code of 7 arriving from the engine, an error strobe and a done strobe arriving in the same cycle, and interrupt causes that occur while the interrupt is disabled; a design that latched those would later assert `irq` with no new cause. Both acknowledge variants run side by side, so a read that clears in the write-acknowledge variant, or a read that fails to clear in the other, is visible.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    localparam int TEC_W = 8;
    localparam int REC_W = 7;
    localparam int REG_W = 16;
    localparam logic [REG_W-1:0] INT_ID_STATUS = 16'h8000;

    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_PARK  = 3'd7
    } lec_e;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_STAT = 2'd1,
        ADR_ERRC = 2'd2,
        ADR_INTR = 2'd3
    } addr_e;

    typedef struct packed {
        logic boff;
        logic ewarn;
        logic epass;
    } flags_t;

    function automatic logic [REG_W-1:0] pack_status(flags_t f, logic rxok, logic txok, lec_e lec);
        return {8'h00, f.boff, f.ewarn, f.epass, rxok, txok, lec};
    endfunction

    function automatic logic [REG_W-1:0] pack_errcnt(logic rp, logic [REC_W-1:0] rec, logic [TEC_W-1:0] tec);
        return {rp, rec, tec};
    endfunction

endpackage

// File: rtl/can_err_counters.sv
module can_err_counters
    import can_stat_pkg::*;
#(
    parameter int TEC_STEP      = 8,
    parameter int REC_STEP      = 1,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tec_inc,
    input  logic             tec_dec,
    input  logic             rec_inc,
    input  logic             rec_dec,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic             rec_pass,
    output flags_t           flags
);

    localparam int TEC_MAX = (1 << TEC_W) - 1;
    localparam int REC_MAX = (1 << REC_W) - 1;

    logic [TEC_W:0] tec_sum;
    logic [REC_W:0] rec_sum;
    logic           boff_q;

    assign tec_sum = {1'b0, tec} + (TEC_W+1)'(TEC_STEP);
    assign rec_sum = {1'b0, rec} + (REC_W+1)'(REC_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            tec    <= '0;
            boff_q <= 1'b0;
        end else if (!boff_q) begin
            if (tec_inc) begin
                if (int'(tec_sum) > TEC_MAX) begin
                    tec    <= TEC_W'(TEC_MAX);
                    boff_q <= 1'b1;
                end else begin
                    tec <= tec_sum[TEC_W-1:0];
                end
            end else if (tec_dec && tec != '0) begin
                tec <= tec - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec      <= '0;
            rec_pass <= 1'b0;
        end else if (rec_inc) begin
            if (int'(rec_sum) > REC_MAX) begin
                rec      <= REC_W'(REC_MAX);
                rec_pass <= 1'b1;
            end else begin
                rec <= rec_sum[REC_W-1:0];
            end
        end else if (rec_dec) begin
            if (rec_pass) begin
                rec_pass <= 1'b0;
            end else if (rec != '0) begin
                rec <= rec - 1'b1;
            end
        end
    end

    always_comb begin
        flags.boff  = boff_q;
        flags.ewarn = boff_q || (int'(tec) >= WARN_LIMIT) || (int'(rec) >= WARN_LIMIT);
        flags.epass = boff_q || (int'(tec) > PASSIVE_LIMIT) || rec_pass;
    end

endmodule

// File: rtl/can_status_regs.sv
module can_status_regs
    import can_stat_pkg::*;
#(
    parameter bit CLEAR_ON_READ = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_ok,
    input  logic       rx_ok,
    input  logic       err_vld,
    input  lec_e       err_code,
    input  logic       cpu_wr,
    input  logic [4:0] cpu_wdata,
    input  logic       cpu_rd,
    output logic       txok,
    output logic       rxok,
    output lec_e       lec,
    output logic       lec_upd
);

    logic rd_clr;
    logic err_take;

    generate
        if (CLEAR_ON_READ) begin : g_rd_ack
            assign rd_clr = cpu_rd;
        end else begin : g_wr_ack
            assign rd_clr = 1'b0;
        end
    endgenerate

    assign err_take = err_vld && (err_code != LEC_PARK);
    assign lec_upd  = tx_ok || rx_ok || err_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            txok <= 1'b0;
            rxok <= 1'b0;
            lec  <= LEC_PARK;
        end else begin
            if (cpu_wr) begin
                rxok <= cpu_wdata[4];
                txok <= cpu_wdata[3];
                lec  <= lec_e'(cpu_wdata[2:0]);
            end else if (rd_clr) begin
                rxok <= 1'b0;
                txok <= 1'b0;
                lec  <= LEC_PARK;
            end
            if (tx_ok) txok <= 1'b1;
            if (rx_ok) rxok <= 1'b1;
            if (err_take) begin
                lec <= err_code;
            end else if (tx_ok || rx_ok) begin
                lec <= LEC_NONE;
            end
        end
    end

endmodule

// File: rtl/can_irq_ctl.sv
module can_irq_ctl
    import can_stat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sie_en,
    input  flags_t flags,
    input  logic   lec_upd,
    input  logic   stat_rd,
    output logic   pending,
    output logic   irq
);

    flags_t flags_q;
    logic   upd_q;
    logic   cause;

    assign cause = (flags != flags_q) || upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            upd_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            flags_q <= flags;
            upd_q   <= lec_upd;
            if (cause && sie_en) begin
                pending <= 1'b1;
            end else if (stat_rd) begin
                pending <= 1'b0;
            end
        end
    end

    assign irq = pending && sie_en;

endmodule

// File: rtl/can_status_unit.sv
module can_status_unit
    import can_stat_pkg::*;
#(
    parameter int TEC_STEP      = 8,
    parameter int REC_STEP      = 1,
    parameter int WARN_LIMIT    = 96,
    parameter int PASSIVE_LIMIT = 127,
    parameter bit CLEAR_ON_READ = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_tx_ok,
    input  logic        ev_rx_ok,
    input  logic        ev_err,
    input  logic [2:0]  ev_err_code,
    input  logic        ev_tec_inc,
    input  logic        ev_tec_dec,
    input  logic        ev_rec_inc,
    input  logic        ev_rec_dec,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq
);

    addr_e            adr;
    logic [TEC_W-1:0] tec_q;
    logic [REC_W-1:0] rec_q;
    logic             rec_pass;
    flags_t           flags;
    logic             bus_off;
    logic             txok_q;
    logic             rxok_q;
    lec_e             lec_q;
    logic             lec_upd;
    logic             sie_en;
    logic             pending;
    logic             stat_wr;
    logic             stat_rd;
    logic             wdata_unused;

    assign adr          = addr_e'(bus_addr);
    assign stat_wr      = bus_wr && (adr == ADR_STAT);
    assign stat_rd      = bus_rd && (adr == ADR_STAT);
    assign bus_off      = flags.boff;
    assign wdata_unused = ^bus_wdata[15:5];

    can_err_counters #(
        .TEC_STEP      (TEC_STEP),
        .REC_STEP      (REC_STEP),
        .WARN_LIMIT    (WARN_LIMIT),
        .PASSIVE_LIMIT (PASSIVE_LIMIT)
    ) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tec_inc  (ev_tec_inc),
        .tec_dec  (ev_tec_dec),
        .rec_inc  (ev_rec_inc),
        .rec_dec  (ev_rec_dec),
        .tec      (tec_q),
        .rec      (rec_q),
        .rec_pass (rec_pass),
        .flags    (flags)
    );

    can_status_regs #(
        .CLEAR_ON_READ (CLEAR_ON_READ)
    ) i_stat (
        .clk       (clk),
        .rst       (rst),
        .tx_ok     (ev_tx_ok),
        .rx_ok     (ev_rx_ok),
        .err_vld   (ev_err),
        .err_code  (lec_e'(ev_err_code)),
        .cpu_wr    (stat_wr),
        .cpu_wdata (bus_wdata[4:0]),
        .cpu_rd    (stat_rd),
        .txok      (txok_q),
        .rxok      (rxok_q),
        .lec       (lec_q),
        .lec_upd   (lec_upd)
    );

    can_irq_ctl i_irq (
        .clk     (clk),
        .rst     (rst),
        .sie_en  (sie_en),
        .flags   (flags),
        .lec_upd (lec_upd),
        .stat_rd (stat_rd),
        .pending (pending),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sie_en <= 1'b0;
        end else if (bus_wr && adr == ADR_CTRL) begin
            sie_en <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (adr)
                ADR_CTRL: bus_rdata <= {15'h0000, sie_en};
                ADR_STAT: bus_rdata <= pack_status(flags, rxok_q, txok_q, lec_q);
                ADR_ERRC: bus_rdata <= pack_errcnt(rec_pass, rec_q, tec_q);
                default:  bus_rdata <= pending ? INT_ID_STATUS : '0;
            endcase
        end
    end

endmodule

// File: rtl/can_status_chk.sv
module can_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_ok,
    input logic       err_vld,
    input logic       tec_inc,
    input logic       tec_dec,
    input logic [2:0] lec,
    input logic [7:0] tec,
    input logic [6:0] rec,
    input logic       rp,
    input logic       boff,
    input logic       sie_en,
    input logic       irq
);

    AST_BOFF_STICKY: assert property (@(posedge clk) disable iff (rst)
        boff |=> boff); // R8

    AST_BOFF_TEC_FULL: assert property (@(posedge clk) disable iff (rst)
        boff |-> tec == 8'hFF); // R8

    AST_REC_PASS_CAP: assert property (@(posedge clk) disable iff (rst)
        rp |-> rec == 7'h7F); // R9

    AST_TXOK_CODE: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && !err_vld) |=> lec == 3'd0); // R2

    AST_TEC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (tec == 8'h00 && tec_dec && !tec_inc && !boff) |=> tec == 8'h00); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> sie_en); // R10

endmodule

bind can_status_unit can_status_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_ok   (ev_tx_ok),
    .err_vld (ev_err),
    .tec_inc (ev_tec_inc),
    .tec_dec (ev_tec_dec),
    .lec     (lec_q),
    .tec     (tec_q),
    .rec     (rec_q),
    .rp      (rec_pass),
    .boff    (bus_off),
    .sie_en  (sie_en),
    .irq     (irq)
);

// File: tb/test_can_status_unit.sv
module test_can_status_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_tx_ok = 0, ev_rx_ok = 0, ev_err = 0;
    logic [2:0]  ev_err_code = 0;
    logic        ev_tec_inc = 0, ev_tec_dec = 0, ev_rec_inc = 0, ev_rec_dec = 0;
    logic [1:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] rdata, rdata_rc;
    logic        irq, irq_rc;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    can_status_unit i_can_status_unit (
        .clk(clk), .rst(rst), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_err(ev_err), .ev_err_code(ev_err_code), .ev_tec_inc(ev_tec_inc),
        .ev_tec_dec(ev_tec_dec), .ev_rec_inc(ev_rec_inc), .ev_rec_dec(ev_rec_dec),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq)
    );

    can_status_unit #(.CLEAR_ON_READ(1'b1)) i_can_status_unit_rc (
        .clk(clk), .rst(rst), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_err(ev_err), .ev_err_code(ev_err_code), .ev_tec_inc(ev_tec_inc),
        .ev_tec_dec(ev_tec_dec), .ev_rec_inc(ev_rec_inc), .ev_rec_dec(ev_rec_dec),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_rc), .irq(irq_rc)
    );

    localparam logic [7:0] S_TX = 8'h01, S_RX = 8'h02, S_ERR = 8'h04, S_TI = 8'h08,
                           S_TD = 8'h10, S_RI = 8'h20, S_RD = 8'h40;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] m, input logic [2:0] code);
        @(negedge clk);
        ev_tx_ok = m[0]; ev_rx_ok = m[1]; ev_err = m[2]; ev_err_code = code;
        ev_tec_inc = m[3]; ev_tec_dec = m[4]; ev_rec_inc = m[5]; ev_rec_dec = m[6];
        @(negedge clk);
        ev_tx_ok = 0; ev_rx_ok = 0; ev_err = 0; ev_err_code = 0;
        ev_tec_inc = 0; ev_tec_dec = 0; ev_rec_inc = 0; ev_rec_dec = 0;
    endtask

    task automatic strobe_n(input logic [7:0] m, input int n);
        for (int i = 0; i < n; i++) strobe(m, 3'd0);
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d, output logic [15:0] d_rc);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rdata;
        d_rc = rdata_rc;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] d, drc;
        do_reset();
        check("R1 irq", {15'h0, irq}, 16'h0);
        reg_read(2'd1, d, drc);
        check("R1 status", d, 16'h0007);
        check("R1 status rc", drc, 16'h0007);
        reg_read(2'd2, d, drc);
        check("R1 errcnt", d, 16'h0000);
        reg_read(2'd0, d, drc);
        check("R1 control", d, 16'h0000);
        reg_read(2'd3, d, drc);
        check("R1 intr id", d, 16'h0000);
    endtask

    task automatic t_status_events();
        logic [15:0] d, drc;
        do_reset();
        strobe(S_TX, 3'd0);
        reg_read(2'd1, d, drc);
        check("R2 tx done", d, 16'h0008);
        check("R4 rc first read", drc, 16'h0008);
        reg_read(2'd1, d, drc);
        check("R3 read does not clear", d, 16'h0008);
        check("R4 rc cleared and parked", drc, 16'h0007);
        reg_write(2'd1, 16'h00E7);
        reg_read(2'd1, d, drc);
        check("R3 write ack, flags read-only", d, 16'h0007);
        strobe(S_RX | S_ERR, 3'd3);
        reg_read(2'd1, d, drc);
        check("R2 rx done + ack error code", d, 16'h0013);
        strobe(S_ERR, 3'd7);
        reg_read(2'd1, d, drc);
        check("R2 code 7 from engine ignored", d, 16'h0013);
        strobe(S_ERR, 3'd6);
        reg_read(2'd1, d, drc);
        check("R2 crc code", d, 16'h0016);
    endtask

    task automatic t_tx_counter();
        logic [15:0] d, drc;
        do_reset();
        strobe(S_TD, 3'd0);
        reg_read(2'd2, d, drc);
        check("R5 decrement floor", d, 16'h0000);
        strobe_n(S_TI, 11);
        reg_read(2'd2, d, drc);
        check("R5 tec 88", d, 16'h0058);
        reg_read(2'd1, d, drc);
        check("R6 no warning at 88", d, 16'h0007);
        strobe(S_TI, 3'd0);
        reg_read(2'd1, d, drc);
        check("R6 warning at 96", d, 16'h0047);
        strobe(S_TD, 3'd0);
        reg_read(2'd2, d, drc);
        check("R5 tec 95", d, 16'h005F);
        reg_read(2'd1, d, drc);
        check("R6 warning drops at 95", d, 16'h0007);
        strobe_n(S_TI, 5);
        reg_read(2'd1, d, drc);
        check("R7 passive at 135", d, 16'h0067);
        strobe_n(S_TI, 15);
        reg_read(2'd2, d, drc);
        check("R8 tec exactly 255", d, 16'h00FF);
        reg_read(2'd1, d, drc);
        check("R8 no bus-off at 255", d, 16'h0067);
        strobe(S_TI, 3'd0);
        reg_read(2'd1, d, drc);
        check("R8 bus-off", d, 16'h00E7);
        reg_read(2'd2, d, drc);
        check("R8 tec held", d, 16'h00FF);
        strobe(S_TD, 3'd0);
        reg_read(2'd2, d, drc);
        check("R8 decrement ignored", d, 16'h00FF);
        reg_read(2'd1, d, drc);
        check("R8 bus-off sticky", d, 16'h00E7);
    endtask

    task automatic t_rx_counter();
        logic [15:0] d, drc;
        do_reset();
        strobe_n(S_RI, 96);
        reg_read(2'd2, d, drc);
        check("R9 rec 96", d, 16'h6000);
        reg_read(2'd1, d, drc);
        check("R6 warning from rec", d, 16'h0047);
        strobe_n(S_RI, 31);
        reg_read(2'd2, d, drc);
        check("R9 rec 127", d, 16'h7F00);
        reg_read(2'd1, d, drc);
        check("R7 not passive at 127", d, 16'h0047);
        strobe(S_RI, 3'd0);
        reg_read(2'd2, d, drc);
        check("R9 saturate + passive bit", d, 16'hFF00);
        reg_read(2'd1, d, drc);
        check("R7 passive from rec", d, 16'h0067);
        strobe(S_RD, 3'd0);
        reg_read(2'd2, d, drc);
        check("R9 first decrement clears bit 15", d, 16'h7F00);
        strobe(S_RD, 3'd0);
        reg_read(2'd2, d, drc);
        check("R9 second decrement", d, 16'h7E00);
    endtask

    task automatic t_interrupt();
        logic [15:0] d, drc;
        do_reset();
        strobe(S_TX, 3'd0);
        @(negedge clk);
        check("R10 disabled no irq", {15'h0, irq}, 16'h0);
        reg_write(2'd0, 16'h0001);
        reg_read(2'd0, d, drc);
        check("R11 control readback", d, 16'h0001);
        check("R10 no stale pending", {15'h0, irq}, 16'h0);
        strobe(S_TX, 3'd0);
        check("R10 not yet after first edge", {15'h0, irq}, 16'h0);
        @(negedge clk);
        check("R10 irq on second edge", {15'h0, irq}, 16'h1);
        reg_read(2'd3, d, drc);
        check("R10 intr id", d, 16'h8000);
        reg_read(2'd1, d, drc);
        check("R10 cleared by status read", {15'h0, irq}, 16'h0);
        strobe_n(S_TI, 11);
        @(negedge clk);
        check("R10 no irq below warning", {15'h0, irq}, 16'h0);
        strobe(S_TI, 3'd0);
        @(negedge clk);
        check("R10 irq on warning change", {15'h0, irq}, 16'h1);
        reg_write(2'd0, 16'h0000);
        check("R10 irq masked by enable", {15'h0, irq}, 16'h0);
    endtask

    initial begin
        t_reset_state();
        t_status_events();
        t_tx_counter();
        t_rx_counter();
        t_interrupt();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule